// File: doc/BRIEF.md
# Byte-to-Word Bus Width Bridge

This block lets a host with an 8-bit data bus read and write a memory that is 16 bits wide. The host moves each word as two byte accesses in a row, and its least significant address bit tells the bridge which half it is handling. The remaining address bits name the memory word. The memory is treated as asynchronous-read static RAM that writes on the clock edge while its write strobe is high.

On a read pair, the first access returns the low byte straight from memory and, in the same cycle, saves the high byte into a holding register. The second access returns the saved byte and does not read memory, so the two halves always come from the same snapshot of the word. On a write pair, the first access only saves the host byte. The second access commits the whole word in one memory write: the upper half comes from the host bus and the lower half from the saved byte. The bridge also checks that each second-half access follows a matching first-half access. When that check fails it pulses an error flag, but it still carries out the access with whatever the holding register contains.

Top module: `byte_word_bridge`

## Requirements
- R1: During any selected access, mem_addr equals host_addr shifted right by one bit, so host bits above bit 0 form the word address.
- R2: A selected read with host_addr[0]=0 drives host_rdata with bits 7:0 of mem_rdata in the same cycle.
- R3: A selected read with host_addr[0]=0 saves bits 15:8 of mem_rdata at the clock edge. A later selected read with host_addr[0]=1 returns that saved byte, even if memory changed in between.
- R4: A selected write with host_addr[0]=0 saves host_wdata and keeps mem_we low.
- R5: A selected write with host_addr[0]=1 raises mem_we for that one cycle, with mem_wdata[15:8] = host_wdata and mem_wdata[7:0] = the saved write byte.
- R6: host_oe is high only when host_sel and host_rd are high and host_wr is low. When host_rd and host_wr are both high, the access is a write. Without host_sel, neither host_oe nor mem_we rises.
- R7: An access is a selected cycle with host_rd or host_wr high. Each access with host_addr[0]=1 is checked against the most recent earlier access with host_addr[0]=0 that has not yet been consumed. The check fails unless that access exists, has the same direction and has the same word address. On failure, seq_err is high for exactly the following cycle; otherwise seq_err stays low. Every access with host_addr[0]=1 consumes the pending access, whether the check passed or failed.
- R8: An access with host_addr[0]=1 that fails the R7 check still completes, using the current contents of the holding register.
- R9: Synchronous active-low reset clears both holding registers to zero, drops any pending first-half access and clears seq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 1 | Host selects the bridge this cycle |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request; takes priority over host_rd |
| host_addr | input | ADDR_W | Host byte address; bit 0 selects the half |
| host_wdata | input | BYTE_W | Byte from host |
| host_rdata | output | BYTE_W | Byte to host |
| host_oe | output | 1 | Enable for the host data pad driver |
| mem_addr | output | ADDR_W-1 | Memory word address |
| mem_rdata | input | 2*BYTE_W | Word read from memory |
| mem_wdata | output | 2*BYTE_W | Word written to memory |
| mem_we | output | 1 | Memory write strobe |
| seq_err | output | 1 | One-cycle pulse for a second-half access that has no matching first half |

## Verification
The bench builds the bridge with ADDR_W=6 and BYTE_W=8. That gives a 32-word stub memory, so the bench can write and read back every word, including the highest word address. With so few words, random traffic often produces pairs whose two halves point at the same word but arrive in the wrong order, have mismatched directions, or come as doubled halves. Directed cases cover the memory changing between the two halves of a read, stale data in the holding registers after an unpaired access, and their cleared state after a reset in the middle of the run.

// File: rtl/bwb_pkg.sv
// Package: shared types for the byte-to-word bridge.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bwb_pkg;

    // Kind of host access decoded for the current cycle.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/bwb_rd_path.sv
// Module: bwb_rd_path
// Read side of the bridge. The first-half read passes the memory low byte
// straight to the host and saves the high byte. The second-half read returns
// the saved byte. Assumes memory read data is valid in the cycle of the access.
module bwb_rd_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [BYTE_W-1:0] mem_lo_byte,
    input  logic [BYTE_W-1:0] mem_hi_byte,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_oe
);

    logic [BYTE_W-1:0] hold_hi;

    // Save the upper memory byte during a first-half read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_hi <= '0;
        end else if (rd_lo) begin
            hold_hi <= mem_hi_byte;
        end
    end

    // Choose the byte for the host: memory for the first half, saved byte otherwise.
    always_comb begin
        host_rdata = rd_lo ? mem_lo_byte : hold_hi;
        host_oe    = rd_lo | rd_hi;
    end

    // A second-half read directly after a first-half read returns the byte saved then.
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (rd_hi |-> host_rdata == $past(mem_hi_byte)));

endmodule

// File: rtl/bwb_wr_path.sv
// Module: bwb_wr_path
// Write side of the bridge. The first-half write saves the host byte. The
// second-half write issues one memory write that joins the host byte with the
// saved byte. Assumes the memory accepts a write at the clock edge.
module bwb_wr_path #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [2*BYTE_W-1:0] mem_wdata,
    output logic                mem_we
);

    logic [BYTE_W-1:0] hold_lo;

    // Save the first-half byte until the second half arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo <= '0;
        end else if (wr_lo) begin
            hold_lo <= host_wdata;
        end
    end

    // Build the full word and raise the strobe only on the second half.
    always_comb begin
        mem_wdata = {host_wdata, hold_lo};
        mem_we    = wr_hi;
    end

    // The low half committed by a pair is the byte written in the cycle before.
    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (wr_hi |-> mem_wdata[BYTE_W-1:0] == $past(host_wdata)));

endmodule

// File: rtl/bwb_pair_track.sv
// Module: bwb_pair_track
// Checks that halves are ordered correctly. It records the latest unconsumed
// first-half access and flags any second-half access whose word address or
// direction does not match it. Assumes one access per cycle at most.
module bwb_pair_track #(
    parameter int WADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bwb_pkg::acc_kind_e acc_kind,
    input  logic               acc_hi,
    input  logic [WADDR_W-1:0] acc_waddr,
    output logic               seq_err
);

    logic               pend_v;
    logic               pend_wr;
    logic [WADDR_W-1:0] pend_addr;
    logic               acc_valid;
    logic               acc_wr;
    logic               pair_ok;

    // Decode the access and compare it with the pending first half.
    always_comb begin
        acc_valid = (acc_kind != bwb_pkg::ACC_IDLE);
        acc_wr    = (acc_kind == bwb_pkg::ACC_WRITE);
        pair_ok   = pend_v && (pend_addr == acc_waddr) && (pend_wr == acc_wr);
    end

    // Record first halves, consume them on second halves, and pulse the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_wr   <= 1'b0;
            pend_addr <= '0;
            seq_err   <= 1'b0;
        end else begin
            seq_err <= acc_valid && acc_hi && !pair_ok;
            if (acc_valid && !acc_hi) begin
                pend_v    <= 1'b1;
                pend_wr   <= acc_wr;
                pend_addr <= acc_waddr;
            end else if (acc_valid) begin
                pend_v <= 1'b0;
            end
        end
    end

    // A matching pair in back-to-back cycles never raises the flag.
    assert_pair_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hi) |=>
        ((acc_valid && acc_hi && acc_wr == $past(acc_wr) && acc_waddr == $past(acc_waddr))
         |=> !seq_err));

endmodule

// File: rtl/byte_word_bridge.sv
// Module: byte_word_bridge (top)
// Connects an 8-bit host bus to a 16-bit memory through two byte accesses
// per word, with host address bit 0 choosing the half. Assumes asynchronous-read
// memory with a write strobe sampled on the clock edge. When the host raises
// read and write together, the access is a write.
module byte_word_bridge #(
    parameter int ADDR_W = 13,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    output logic                host_oe,
    output logic [ADDR_W-2:0]   mem_addr,
    input  logic [2*BYTE_W-1:0] mem_rdata,
    output logic [2*BYTE_W-1:0] mem_wdata,
    output logic                mem_we,
    output logic                seq_err
);

    localparam int WADDR_W = ADDR_W - 1;
    localparam int WORD_W  = 2 * BYTE_W;

    bwb_pkg::acc_kind_e acc_kind;
    logic               phase_hi;
    logic               rd_lo, rd_hi, wr_lo, wr_hi;

    // Decode the access kind and its half from the host strobes.
    always_comb begin
        if (!host_sel)     acc_kind = bwb_pkg::ACC_IDLE;
        else if (host_wr)  acc_kind = bwb_pkg::ACC_WRITE;
        else if (host_rd)  acc_kind = bwb_pkg::ACC_READ;
        else               acc_kind = bwb_pkg::ACC_IDLE;
        phase_hi = host_addr[0];
        rd_lo    = (acc_kind == bwb_pkg::ACC_READ)  && !phase_hi;
        rd_hi    = (acc_kind == bwb_pkg::ACC_READ)  &&  phase_hi;
        wr_lo    = (acc_kind == bwb_pkg::ACC_WRITE) && !phase_hi;
        wr_hi    = (acc_kind == bwb_pkg::ACC_WRITE) &&  phase_hi;
        mem_addr = host_addr[ADDR_W-1:1];
    end

    bwb_rd_path #(.BYTE_W(BYTE_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_lo       (rd_lo),
        .rd_hi       (rd_hi),
        .mem_lo_byte (mem_rdata[BYTE_W-1:0]),
        .mem_hi_byte (mem_rdata[WORD_W-1:BYTE_W]),
        .host_rdata  (host_rdata),
        .host_oe     (host_oe)
    );

    bwb_wr_path #(.BYTE_W(BYTE_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .host_wdata (host_wdata),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we)
    );

    bwb_pair_track #(.WADDR_W(WADDR_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_kind  (acc_kind),
        .acc_hi    (phase_hi),
        .acc_waddr (host_addr[ADDR_W-1:1]),
        .seq_err   (seq_err)
    );

    // The host driver is enabled only for a selected read that is not also a write.
    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe |-> (host_sel && host_rd && !host_wr));

    // A first-half access never writes memory.
    assert_no_lo_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_addr[0]) |-> !mem_we);

    // With the bridge deselected, nothing reaches either bus.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (!host_oe && !mem_we));

endmodule

// File: tb/sim_byte_word_bridge.sv
// Bench for byte_word_bridge: a behavioural reference model checked every clock.
module sim_byte_word_bridge;

    localparam int AW    = 6;
    localparam int BW    = 8;
    localparam int WORDS = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [BW-1:0] host_wdata = '0;
    logic [BW-1:0] host_rdata;
    logic          host_oe;
    logic [AW-2:0] mem_addr;
    logic [15:0]   mem_rdata, mem_wdata;
    logic          mem_we, seq_err;

    logic [15:0]   stub [WORDS];
    logic          poke_en = 1'b0;
    logic [AW-2:0] poke_addr = '0;
    logic [15:0]   poke_data = '0;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int ref_mem [WORDS];
    int ref_hi, ref_lo, pend_addr, exp_err;
    bit pend_v, pend_wr;

    always #10 clk = ~clk;

    byte_word_bridge #(.ADDR_W(AW), .BYTE_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_oe(host_oe), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .seq_err(seq_err)
    );

    // Memory stub: asynchronous read, write on the edge.
    assign mem_rdata = stub[mem_addr];
    always @(posedge clk) begin
        if (poke_en) stub[poke_addr] <= poke_data;
        else if (mem_we) stub[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ref_hi = 0; ref_lo = 0; pend_v = 0; pend_wr = 0; pend_addr = 0; exp_err = 0;
    endtask

    // One host cycle: drive at the falling edge, check just before the rising edge.
    task automatic step(input bit sel, input bit rd, input bit wr,
                        input int addr, input int wdata);
        int  wa;
        bit  a0, is_rd, is_wr, ok;
        host_sel = sel; host_rd = rd; host_wr = wr;
        host_addr = AW'(addr); host_wdata = BW'(wdata);
        #8;
        wa = (addr >> 1) & (WORDS - 1);
        a0 = addr[0];
        is_wr = sel && wr;
        is_rd = sel && rd && !wr;
        chk("R6 host_oe", int'(host_oe), int'(is_rd));
        if (is_rd && !a0) chk("R2 low byte read", int'(host_rdata), ref_mem[wa] & 8'hff);
        if (is_rd && a0)  chk("R3/R8 saved byte read", int'(host_rdata), ref_hi);
        chk("R4/R5 mem_we", int'(mem_we), int'(is_wr && a0));
        if (is_wr && a0) chk("R5 mem_wdata", int'(mem_wdata), ((wdata & 8'hff) << 8) | ref_lo);
        if (sel) chk("R1 mem_addr", int'(mem_addr), wa);
        chk("R7 seq_err", int'(seq_err), exp_err);
        // Advance the model as of the coming edge.
        ok = pend_v && (pend_addr == wa) && (pend_wr == is_wr);
        exp_err = ((is_rd || is_wr) && a0 && !ok) ? 1 : 0;
        if (is_rd && !a0) ref_hi = (ref_mem[wa] >> 8) & 8'hff;
        if (is_wr && !a0) ref_lo = wdata & 8'hff;
        if (is_wr && a0)  ref_mem[wa] = ((wdata & 8'hff) << 8) | ref_lo;
        if ((is_rd || is_wr) && !a0) begin
            pend_v = 1; pend_wr = is_wr; pend_addr = wa;
        end else if (is_rd || is_wr) begin
            pend_v = 0;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        host_sel = 0; host_rd = 0; host_wr = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic poke(input int wa, input int val);
        poke_en = 1; poke_addr = (AW-1)'(wa); poke_data = 16'(val);
        ref_mem[wa] = val & 16'hffff;
        @(negedge clk);
        poke_en = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            stub[i] = 16'h0000;
            ref_mem[i] = 0;
        end
        model_reset();
        @(negedge clk);
        do_reset();

        // R9: unpaired second-half read straight after reset returns zero and flags an error.
        step(1, 1, 0, 3, 0);
        // R9/R8: unpaired second-half write commits zero in the low half.
        step(1, 0, 1, 5, 8'hc3);
        step(0, 0, 0, 0, 0);   // R7: seq_err pulse seen here

        // R5/R1: paired writes to every word, including the top one.
        for (int w = 0; w < WORDS; w++) begin
            step(1, 0, 1, 2*w,     (w * 37 + 11) & 8'hff);
            step(1, 0, 1, 2*w + 1, (w * 91 + 5) & 8'hff);
        end
        // R2/R3: paired reads of every word.
        for (int w = WORDS - 1; w >= 0; w--) begin
            step(1, 1, 0, 2*w, 0);
            step(1, 1, 0, 2*w + 1, 0);
        end

        // R3: memory changes between the halves; the second half returns the old byte.
        step(1, 1, 0, 8, 0);
        poke(4, 16'h5aa5);
        step(1, 1, 0, 9, 0);
        step(0, 0, 0, 0, 0);

        // R7/R8: halves with mismatched addresses, mismatched direction, and a doubled second half.
        step(1, 0, 1, 10, 8'h77);
        step(1, 0, 1, 13, 8'h88);   // wrong word
        step(1, 1, 0, 14, 0);
        step(1, 0, 1, 15, 8'h99);   // wrong direction
        step(1, 1, 0, 15, 0);       // doubled second half
        step(0, 0, 0, 0, 0);

        // R6: read and write together is a write; a deselected read drives nothing.
        step(1, 1, 1, 20, 8'h3c);
        step(1, 1, 1, 21, 8'he1);
        step(0, 1, 0, 20, 0);
        step(0, 0, 1, 21, 8'h12);
        step(1, 1, 0, 20, 0);
        step(1, 1, 0, 21, 0);

        // R9: a reset mid-run clears the holding registers and the pending half.
        step(1, 1, 0, 8, 0);
        step(1, 0, 1, 6, 8'hff);
        do_reset();
        step(1, 1, 0, 9, 0);
        step(1, 0, 1, 7, 8'h44);
        step(0, 0, 0, 0, 0);

        // Random traffic over the small address space.
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom;
            step(r[2:0] != 0, r[3], r[4], int'(r[13:8]) % (2 * WORDS), int'(r[23:16]));
        end

        step(0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule